// File: doc/BRIEF.md
# Power Rail Start/Stop Sequencer

This block governs how one regulated output rail comes up and goes down. Once the enable input rises, it holds the voltage-reference setpoint at code zero for a programmable number of clock cycles. It then moves the setpoint toward the commanded target code in equal fractional steps, while the feedback loop stays closed. The slope is set by the programmed rise time and the target, and the last step lands exactly on the target. When enable falls, a programmable off delay runs first, and then the setpoint ramps back to zero over the programmed fall time.

A mode output tells the compensator which coefficient set to use. It is high while the reference is ramping and low while the rail holds or regulates. A power-good output is high only while the rail regulates. When the tracking input is set, the rail follows the reference code of another rail instead of its own ramp, and that code is limited to the rail's own target. Every clock cycle counts as one timing tick.

Top module: `rail_seq`

## Requirements
- R1: During reset and in the idle state, setpoint, ramp_mode and pgood are all 0.
- R2: The cycle after enable is seen in idle, the turn-on delay starts. Setpoint stays 0 and ramp_mode stays 0 for on_delay+1 cycles. The ramp then starts from code 0, with ramp_mode 1.
- R3: On rise step k (1 ≤ k < rise_time), setpoint equals floor(target·k / rise_time). After max(rise_time,1) steps, setpoint equals target exactly. A rise_time of 0 goes straight to target.
- R4: ramp_mode is 1 exactly while the setpoint rises or falls, and 0 in idle, in both delays and in regulation.
- R5: pgood is 1 only in regulation, and the setpoint then equals the target code. This does not apply while tracking.
- R6: The first cycle after enable is seen low in regulation, pgood is 0. The setpoint then holds the target for off_delay+1 cycles with ramp_mode 0.
- R7: A fall from start code S runs as follows. On fall step k (k < fall_time), setpoint equals S − floor(S·k / fall_time). After max(fall_time,1) steps, the block is idle with setpoint 0.
- R8: If enable drops while the setpoint is rising, the block skips the off delay. It falls from the setpoint it has reached at that moment.
- R9: If enable drops during the turn-on delay, the block returns to idle and no ramp starts.
- R10: Raising enable during a fall has no effect. The fall completes on its normal profile down to idle.
- R11: With track_en set, the setpoint equals min(track_ref, target) one cycle later in the rise, regulation, off-delay and fall states. In idle and during the turn-on delay it stays 0.
- R12: If enable returns during the off delay, the block goes back to regulation with pgood set and the setpoint at target.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; each cycle is one timing tick |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Rail on request |
| on_delay | input | TIME_W | Turn-on delay in ticks |
| off_delay | input | TIME_W | Turn-off delay in ticks |
| rise_time | input | TIME_W | Rise ramp length in ticks |
| fall_time | input | TIME_W | Fall ramp length in ticks |
| target | input | CODE_W | Commanded regulation setpoint code |
| track_en | input | 1 | Follow the other rail's reference |
| track_ref | input | CODE_W | Reference code of the rail being tracked |
| setpoint | output | CODE_W | Reference setpoint code to the loop |
| ramp_mode | output | 1 | 1 selects ramp coefficients, 0 regulation coefficients |
| pgood | output | 1 | Rail is in regulation |

## Verification
The bench builds the block with a 10-bit setpoint code and 8-bit tick counters. With these widths, full-scale codes such as 1023 and ramps of 0, 1, 3 and 16 ticks are reached within a few dozen cycles. Zero-length delays and ramps, targets smaller than the ramp length (most steps add nothing), and aborts part-way through a ramp all fit inside short directed runs. Every point of each ramp is compared against the floor formula.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ONDLY  = 3'd1,
        ST_RISE   = 3'd2,
        ST_REG    = 3'd3,
        ST_OFFDLY = 3'd4,
        ST_FALL   = 3'd5
    } seq_state_e;

endpackage

// File: rtl/rail_seq_div.sv
// Combinational restoring divider: one compare/subtract stage per numerator bit.
module rail_seq_div #(
    parameter int NUM_W = 12,
    parameter int DEN_W = 16
) (
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic [NUM_W-1:0] quo,
    output logic [DEN_W-1:0] rem
);

    logic [NUM_W:0][DEN_W-1:0] part;
    logic [NUM_W-1:0]          qbit;

    assign part[NUM_W] = '0;

    for (genvar i = NUM_W - 1; i >= 0; i--) begin : g_stage
        logic [DEN_W:0] trial;
        logic           ge;
        assign trial   = {part[i+1], num[i]};
        assign ge      = trial >= {1'b0, den};
        assign qbit[i] = ge;
        assign part[i] = ge ? DEN_W'(trial - {1'b0, den}) : trial[DEN_W-1:0];
    end

    assign quo = (den == '0) ? '0 : qbit;
    assign rem = (den == '0) ? '0 : part[0];

endmodule

// File: rtl/rail_seq_step.sv
// One ramp step: integer quotient plus a carry from the fractional accumulator.
module rail_seq_step #(
    parameter int CODE_W = 12,
    parameter int TIME_W = 16
) (
    input  logic              dir_up,
    input  logic [CODE_W-1:0] value,
    input  logic [TIME_W-1:0] acc,
    input  logic [CODE_W-1:0] quo,
    input  logic [TIME_W-1:0] rem,
    input  logic [TIME_W-1:0] den,
    output logic [CODE_W-1:0] value_nx,
    output logic [TIME_W-1:0] acc_nx
);

    logic [TIME_W:0]   acc_sum;
    logic              carry;
    logic [CODE_W-1:0] step_amt;

    always_comb begin
        acc_sum  = {1'b0, acc} + {1'b0, rem};
        carry    = acc_sum >= {1'b0, den};
        acc_nx   = carry ? TIME_W'(acc_sum - {1'b0, den}) : TIME_W'(acc_sum);
        step_amt = quo + CODE_W'(carry);
        value_nx = dir_up ? (value + step_amt) : (value - step_amt);
    end

endmodule

// File: rtl/rail_seq.sv
module rail_seq
    import rail_seq_pkg::*;
#(
    parameter int CODE_W = 12,
    parameter int TIME_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [TIME_W-1:0] on_delay,
    input  logic [TIME_W-1:0] off_delay,
    input  logic [TIME_W-1:0] rise_time,
    input  logic [TIME_W-1:0] fall_time,
    input  logic [CODE_W-1:0] target,
    input  logic              track_en,
    input  logic [CODE_W-1:0] track_ref,
    output logic [CODE_W-1:0] setpoint,
    output logic              ramp_mode,
    output logic              pgood
);

    localparam logic [TIME_W-1:0] ONE_TICK = TIME_W'(1);

    typedef struct packed {
        seq_state_e        state;
        logic [TIME_W-1:0] cnt;
        logic [CODE_W-1:0] ramp;
        logic [TIME_W-1:0] acc;
        logic [CODE_W-1:0] quo;
        logic [TIME_W-1:0] rem;
        logic [TIME_W-1:0] den;
        logic [CODE_W-1:0] sp;
        logic              mode;
        logic              pg;
    } seq_regs_t;

    localparam seq_regs_t RESET_VAL = '0;

    seq_regs_t r_d, r_q;

    // shared divider: slope for a rise (target / rise_time) or a fall (ramp / fall_time)
    logic [CODE_W-1:0] div_num_d;
    logic [TIME_W-1:0] div_den_d;
    logic [CODE_W-1:0] div_quo;
    logic [TIME_W-1:0] div_rem;

    assign div_num_d = (r_q.state == ST_ONDLY) ? target    : r_q.ramp;
    assign div_den_d = (r_q.state == ST_ONDLY) ? rise_time : fall_time;

    rail_seq_div #(
        .NUM_W (CODE_W),
        .DEN_W (TIME_W)
    ) u_div (
        .num (div_num_d),
        .den (div_den_d),
        .quo (div_quo),
        .rem (div_rem)
    );

    logic [CODE_W-1:0] step_val_d;
    logic [TIME_W-1:0] step_acc_d;

    rail_seq_step #(
        .CODE_W (CODE_W),
        .TIME_W (TIME_W)
    ) u_step (
        .dir_up   (r_q.state == ST_RISE),
        .value    (r_q.ramp),
        .acc      (r_q.acc),
        .quo      (r_q.quo),
        .rem      (r_q.rem),
        .den      (r_q.den),
        .value_nx (step_val_d),
        .acc_nx   (step_acc_d)
    );

    logic [CODE_W-1:0] track_lim_d;
    assign track_lim_d = (track_ref < target) ? track_ref : target;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                r_d.ramp = '0;
                r_d.acc  = '0;
                if (en) begin
                    r_d.state = ST_ONDLY;
                    r_d.cnt   = on_delay;
                end
            end
            ST_ONDLY: begin
                if (!en) begin
                    r_d.state = ST_IDLE;
                end else if (r_q.cnt == '0) begin
                    r_d.state = ST_RISE;
                    r_d.cnt   = rise_time;
                    r_d.den   = rise_time;
                    r_d.quo   = div_quo;
                    r_d.rem   = div_rem;
                    r_d.acc   = '0;
                    r_d.ramp  = '0;
                end else begin
                    r_d.cnt = r_q.cnt - ONE_TICK;
                end
            end
            ST_RISE: begin
                if (!en) begin
                    // abort: fall from the value reached so far
                    r_d.state = ST_FALL;
                    r_d.cnt   = fall_time;
                    r_d.den   = fall_time;
                    r_d.quo   = div_quo;
                    r_d.rem   = div_rem;
                    r_d.acc   = '0;
                end else if (r_q.cnt <= ONE_TICK) begin
                    r_d.state = ST_REG;
                    r_d.ramp  = target;
                end else begin
                    r_d.ramp = step_val_d;
                    r_d.acc  = step_acc_d;
                    r_d.cnt  = r_q.cnt - ONE_TICK;
                end
            end
            ST_REG: begin
                r_d.ramp = target;
                if (!en) begin
                    r_d.state = ST_OFFDLY;
                    r_d.cnt   = off_delay;
                end
            end
            ST_OFFDLY: begin
                if (en) begin
                    r_d.state = ST_REG;
                    r_d.ramp  = target;
                end else if (r_q.cnt == '0) begin
                    r_d.state = ST_FALL;
                    r_d.cnt   = fall_time;
                    r_d.den   = fall_time;
                    r_d.quo   = div_quo;
                    r_d.rem   = div_rem;
                    r_d.acc   = '0;
                end else begin
                    r_d.cnt = r_q.cnt - ONE_TICK;
                end
            end
            ST_FALL: begin
                if (r_q.cnt <= ONE_TICK) begin
                    r_d.state = ST_IDLE;
                    r_d.ramp  = '0;
                end else begin
                    r_d.ramp = step_val_d;
                    r_d.acc  = step_acc_d;
                    r_d.cnt  = r_q.cnt - ONE_TICK;
                end
            end
            default: begin
                r_d = RESET_VAL;
            end
        endcase

        // registered outputs follow the next state
        if (r_d.state == ST_IDLE || r_d.state == ST_ONDLY) begin
            r_d.sp = '0;
        end else if (track_en) begin
            r_d.sp = track_lim_d;
        end else begin
            r_d.sp = r_d.ramp;
        end
        r_d.mode = (r_d.state == ST_RISE) || (r_d.state == ST_FALL);
        r_d.pg   = (r_d.state == ST_REG);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= RESET_VAL;
        end else begin
            r_q <= r_d;
        end
    end

    assign setpoint  = r_q.sp;
    assign ramp_mode = r_q.mode;
    assign pgood     = r_q.pg;

endmodule

// File: rtl/rail_seq_chk.sv
module rail_seq_chk #(
    parameter int CODE_W = 12,
    parameter int TIME_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic [TIME_W-1:0] on_delay,
    input logic [TIME_W-1:0] off_delay,
    input logic [TIME_W-1:0] rise_time,
    input logic [TIME_W-1:0] fall_time,
    input logic [CODE_W-1:0] target,
    input logic              track_en,
    input logic [CODE_W-1:0] track_ref,
    input logic [CODE_W-1:0] setpoint,
    input logic              ramp_mode,
    input logic              pgood
);

    // R2: entering a ramp (from a delay) does not jump the setpoint
    p_ramp_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!track_en) && $past(!track_en, 2) && $rose(ramp_mode)) |-> $stable(setpoint));

    // R5: in regulation without tracking the setpoint sits on the target
    p_pgood_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pgood && $past(!track_en)) |-> (setpoint == $past(target)));

    // R6: enable low while good drops power-good on the next cycle
    p_pgood_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pgood && !en) |=> !pgood);

    // R7: with enable held low, a ramp never moves upward
    p_fall_mono_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp_mode && $past(ramp_mode) && $past(!en) && $past(!track_en) && $past(!track_en, 2))
        |-> (setpoint <= $past(setpoint)));

    // R11: tracking never lifts a regulating rail above its own target
    p_track_cap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (pgood && $past(track_en)) |-> (setpoint <= $past(target)));

endmodule

bind rail_seq rail_seq_chk #(
    .CODE_W (CODE_W),
    .TIME_W (TIME_W)
) u_rail_seq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .on_delay  (on_delay),
    .off_delay (off_delay),
    .rise_time (rise_time),
    .fall_time (fall_time),
    .target    (target),
    .track_en  (track_en),
    .track_ref (track_ref),
    .setpoint  (setpoint),
    .ramp_mode (ramp_mode),
    .pgood     (pgood)
);

// File: tb/rail_seq_bench.sv
module rail_seq_bench;

    localparam int CLK_P  = 10;
    localparam int CW     = 10;
    localparam int TW     = 8;
    localparam int N_ROWS = 5;
    // columns: on_delay, rise_time, target, off_delay, fall_time
    localparam int TBL [N_ROWS][5] = '{
        '{3,  8,  800, 2,  4},
        '{0,  1,    5, 0,  1},
        '{2,  7, 1023, 1,  3},
        '{1, 16,    3, 3, 16},
        '{4,  0,  500, 0,  0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic [TW-1:0] on_delay = '0;
    logic [TW-1:0] off_delay = '0;
    logic [TW-1:0] rise_time = '0;
    logic [TW-1:0] fall_time = '0;
    logic [CW-1:0] target = '0;
    logic          track_en = 1'b0;
    logic [CW-1:0] track_ref = '0;
    logic [CW-1:0] setpoint;
    logic          ramp_mode;
    logic          pgood;

    int n_checks = 0;
    int n_errs   = 0;
    bit done     = 1'b0;

    always #(CLK_P / 2) clk = ~clk;

    rail_seq #(.CODE_W(CW), .TIME_W(TW)) u_rail_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .on_delay  (on_delay),
        .off_delay (off_delay),
        .rise_time (rise_time),
        .fall_time (fall_time),
        .target    (target),
        .track_en  (track_en),
        .track_ref (track_ref),
        .setpoint  (setpoint),
        .ramp_mode (ramp_mode),
        .pgood     (pgood)
    );

    task automatic chk(string tag, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errs++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic chk_all(string tag, int sp, int md, int pg);
        chk(tag, "setpoint", int'(setpoint), sp);
        chk(tag, "ramp_mode", int'(ramp_mode), md);
        chk(tag, "pgood", int'(pgood), pg);
    endtask

    // Enable from idle; check delay, every rise step and regulation entry.
    // abort_k >= 0 returns right after checking rise step abort_k.
    task automatic run_up(int d, int r, int t, int abort_k);
        int rr   = (r < 1) ? 1 : r;
        int last = d + 2 + rr;
        on_delay  = TW'(d);
        rise_time = TW'(r);
        target    = CW'(t);
        en        = 1'b1;
        for (int n = 1; n <= last; n++) begin
            @(negedge clk);
            if (n <= d + 1) begin
                chk_all("R2", 0, 0, 0);
            end else if (n < last) begin
                int k = n - d - 2;
                chk_all("R3/R4", (k == 0) ? 0 : (t * k) / r, 1, 0);
                if (k == abort_k) return;
            end else begin
                chk_all("R3/R5", t, 0, 1);
            end
        end
    endtask

    // Drop enable; o < 0 means the fall starts on the next edge (no off delay).
    task automatic run_down(int o, int f, int t, int reassert_k, string tag);
        int ff   = (f < 1) ? 1 : f;
        int b    = o + 2;
        int last = b + ff;
        if (o >= 0) off_delay = TW'(o);
        fall_time = TW'(f);
        en        = 1'b0;
        for (int n = 1; n <= last; n++) begin
            @(negedge clk);
            if (n <= o + 1) begin
                chk_all("R6", t, 0, 0);
            end else if (n < last) begin
                int k = n - b;
                chk_all(tag, t - ((k == 0) ? 0 : (t * k) / f), 1, 0);
                if (k == reassert_k) en = 1'b1;
            end else begin
                chk_all(tag, 0, 0, 0);
            end
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_errs++;
            $display("FAIL watchdog (all R): actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk_all("R1", 0, 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_all("R1", 0, 0, 0);

        // table of up/down sequences
        for (int i = 0; i < N_ROWS; i++) begin
            run_up(TBL[i][0], TBL[i][1], TBL[i][2], -1);
            repeat (2) begin
                @(negedge clk);
                chk_all("R5", TBL[i][2], 0, 1);
            end
            run_down(TBL[i][3], TBL[i][4], TBL[i][2], -1, "R7");
            @(negedge clk);
            chk_all("R1", 0, 0, 0);
        end

        // R8: abort during rise at step 3 of 8 (800 -> 300), fall over 4 ticks
        run_up(0, 8, 800, 3);
        run_down(-1, 4, 300, -1, "R8");
        @(negedge clk);
        chk_all("R8", 0, 0, 0);

        // R9: abort during the turn-on delay
        on_delay = TW'(5);
        en = 1'b1;
        @(negedge clk);
        chk_all("R9", 0, 0, 0);
        en = 1'b0;
        repeat (8) begin
            @(negedge clk);
            chk_all("R9", 0, 0, 0);
        end

        // R10: enable raised at fall step 2 is ignored
        run_up(0, 2, 400, -1);
        run_down(0, 4, 400, 2, "R10");
        @(negedge clk);
        chk_all("R10", 0, 0, 0);
        en = 1'b0;
        @(negedge clk);
        chk_all("R10", 0, 0, 0);

        // R12: enable returns during the off delay
        run_up(0, 1, 700, -1);
        off_delay = TW'(4);
        en = 1'b0;
        @(negedge clk);
        chk_all("R6", 700, 0, 0);
        en = 1'b1;
        @(negedge clk);
        chk_all("R12", 700, 0, 1);
        run_down(0, 2, 700, -1, "R7");

        // R11: tracking in regulation, with clamp to own target
        run_up(2, 4, 600, -1);
        track_en  = 1'b1;
        track_ref = CW'(200);
        @(negedge clk);
        chk_all("R11", 200, 0, 1);
        track_ref = CW'(1000);
        @(negedge clk);
        chk_all("R11", 600, 0, 1);
        track_en = 1'b0;
        @(negedge clk);
        chk_all("R11", 600, 0, 1);
        run_down(1, 2, 600, -1, "R7");

        // R11: tracking has no effect during the turn-on delay
        track_en  = 1'b1;
        track_ref = CW'(300);
        on_delay  = TW'(3);
        en        = 1'b1;
        repeat (4) begin
            @(negedge clk);
            chk_all("R11", 0, 0, 0);
        end
        en = 1'b0;
        @(negedge clk);
        chk_all("R11", 0, 0, 0);
        track_en = 1'b0;
        @(negedge clk);
        chk_all("R1", 0, 0, 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule